// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block decides how an external interrupt-acknowledge bus cycle ends and which vector number the processor receives for it. When the bus controller reports that an acknowledge cycle has started, the block captures the requested interrupt level. It then waits for one of two ways to end the cycle. The first is an autovector request, which can come from an external pin or from internal chip-select decoding. In that case the vector is generated locally from the captured level. The second is a data acknowledge from the interrupting device. In that case the device's vector byte is latched as the vector.

Autovector requests only count inside an acknowledge cycle, and only while the processor owns the bus. When an external master holds the bus, the autovector path is switched off and only a data acknowledge can end the cycle. The result is a registered vector number, a flag that tells whether it was autogenerated, and a one-clock done strobe.

Top module: `ivecResolve`

## Requirements
- R1: After reset, vecDone, vecAuto and vecNum are all 0.
- R2: An acknowledge cycle is signalled by cycleKind equal to 2'b11. The level on irqLevel is captured on the first clock edge of that cycle. On any later edge of the same cycle where extAutoVec is 1 and extMasterOwns is 0, the cycle ends: after that edge vecDone is 1, vecAuto is 1 and vecNum equals 24 plus the captured level (level 1 gives 25, level 7 gives 31).
- R3: The chip-select request csAutoVec ends the cycle with an autovector in exactly the same way as extAutoVec.
- R4: With no effective autovector request, a dataAck of 1 on an edge after the first one ends the cycle. After that edge vecDone is 1, vecAuto is 0 and vecNum equals the extVector byte sampled on that edge.
- R5: When an effective autovector request and dataAck occur on the same edge, the autovector wins.
- R6: When cycleKind is not 2'b11, extAutoVec, csAutoVec and dataAck are ignored: vecDone stays 0 and vecNum holds its value.
- R7: While extMasterOwns is 1, both autovector requests are ignored. The cycle then ends only on dataAck, with the external vector.
- R8: vecDone is high for exactly one clock, and at most once per acknowledge cycle. vecNum and vecAuto hold their values between done strobes.
- R9: If an autovector request is held high continuously, every successive acknowledge cycle ends with the autovector for its own level.
- R10: If cycleKind leaves 2'b11 before the cycle has ended, no done strobe is produced for that cycle.
- R11: Changes on irqLevel after the first edge of an acknowledge cycle do not affect that cycle's autovector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleKind | input | 2 | Current bus cycle type; 2'b11 is interrupt acknowledge |
| irqLevel | input | 3 | Requested interrupt level |
| extAutoVec | input | 1 | Autovector request from the external pin |
| csAutoVec | input | 1 | Autovector request from chip-select logic |
| extMasterOwns | input | 1 | An external bus master owns the bus |
| dataAck | input | 1 | Device data acknowledge ending the cycle |
| extVector | input | 8 | Vector byte supplied by the device |
| vecNum | output | 8 | Resolved vector number |
| vecDone | output | 1 | One-clock strobe: the cycle has ended and vecNum is valid |
| vecAuto | output | 1 | The vector was generated locally |

## Verification
The hardest case to reach is an acknowledge cycle that must end only on the device acknowledge while a chip-select or pin autovector request is active, because the bus is owned by an external master. It is easy to miss a case where the wrong source wins. Random cycles therefore draw the ownership flag, both request sources and the acknowledge independently, so every combination turns up. Directed sequences then hold a request high across back-to-back cycles, change the level in mid-cycle, and abort cycles before they end.

// File: rtl/ivecPkg.sv
package ivecPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } ackState_t;

  typedef struct packed {
    logic loadLevel;
    logic finishAuto;
    logic finishExt;
  } ackStrobes_t;

endpackage

// File: rtl/ivecCtrl.sv
module ivecCtrl
  import ivecPkg::*;
#(
  parameter int KIND_W = 2,
  parameter logic [KIND_W-1:0] INTACK_CODE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KIND_W-1:0] cycleKind,
  input  logic              extAutoVec,
  input  logic              csAutoVec,
  input  logic              extMasterOwns,
  input  logic              dataAck,
  output ackStrobes_t       strobes
);

  ackState_t state, nextState;
  logic inAck;
  logic autoReq;

  assign inAck   = (cycleKind == INTACK_CODE);
  // either source may request an autovector; bus ownership gates both
  assign autoReq = (extAutoVec | csAutoVec) & ~extMasterOwns;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (inAck) begin
          strobes.loadLevel = 1'b1;
          nextState         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!inAck) begin
          nextState = ST_IDLE;
        end else if (autoReq) begin
          strobes.finishAuto = 1'b1;
          nextState          = ST_HOLD;
        end else if (dataAck) begin
          strobes.finishExt = 1'b1;
          nextState         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!inAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/ivecPath.sv
module ivecPath
  import ivecPkg::*;
#(
  parameter int LEVEL_W   = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ackStrobes_t        strobes,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic [VEC_W-1:0]   extVector,
  output logic [VEC_W-1:0]   vecNum,
  output logic               vecDone,
  output logic               vecAuto
);

  localparam int PAD_W = VEC_W - LEVEL_W;
  localparam logic [VEC_W-1:0] BASE_VEC = VEC_W'(AUTO_BASE);

  logic [LEVEL_W-1:0] levelReg;
  logic [VEC_W-1:0]   autoVec;

  assign autoVec = BASE_VEC + {{PAD_W{1'b0}}, levelReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelReg <= '0;
    end else if (strobes.loadLevel) begin
      levelReg <= irqLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecNum  <= '0;
      vecAuto <= 1'b0;
      vecDone <= 1'b0;
    end else begin
      vecDone <= strobes.finishAuto | strobes.finishExt;
      if (strobes.finishAuto) begin
        vecNum  <= autoVec;
        vecAuto <= 1'b1;
      end else if (strobes.finishExt) begin
        vecNum  <= extVector;
        vecAuto <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ivecResolve.sv
module ivecResolve
  import ivecPkg::*;
#(
  parameter int KIND_W    = 2,
  parameter int LEVEL_W   = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter logic [KIND_W-1:0] INTACK_CODE = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KIND_W-1:0]  cycleKind,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic               extAutoVec,
  input  logic               csAutoVec,
  input  logic               extMasterOwns,
  input  logic               dataAck,
  input  logic [VEC_W-1:0]   extVector,
  output logic [VEC_W-1:0]   vecNum,
  output logic               vecDone,
  output logic               vecAuto
);

  ackStrobes_t strobes;

  ivecCtrl #(
    .KIND_W      (KIND_W),
    .INTACK_CODE (INTACK_CODE)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .cycleKind     (cycleKind),
    .extAutoVec    (extAutoVec),
    .csAutoVec     (csAutoVec),
    .extMasterOwns (extMasterOwns),
    .dataAck       (dataAck),
    .strobes       (strobes)
  );

  ivecPath #(
    .LEVEL_W   (LEVEL_W),
    .VEC_W     (VEC_W),
    .AUTO_BASE (AUTO_BASE)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .irqLevel  (irqLevel),
    .extVector (extVector),
    .vecNum    (vecNum),
    .vecDone   (vecDone),
    .vecAuto   (vecAuto)
  );

endmodule

// File: rtl/ivecResolve_chk.sv
module ivecResolve_chk #(
  parameter int KIND_W    = 2,
  parameter int LEVEL_W   = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter logic [KIND_W-1:0] INTACK_CODE = '1
) (
  input logic               clk,
  input logic               rstN,
  input logic [KIND_W-1:0]  cycleKind,
  input logic               extAutoVec,
  input logic               csAutoVec,
  input logic               extMasterOwns,
  input logic               dataAck,
  input logic [VEC_W-1:0]   extVector,
  input logic [VEC_W-1:0]   vecNum,
  input logic               vecDone,
  input logic               vecAuto
);

  localparam int AUTO_TOP = AUTO_BASE + (1 << LEVEL_W) - 1;

  // R1: outputs quiet in the cycle after reset
  always_ff @(posedge clk) begin
    if ($past(!rstN) && rstN) begin
      assert_reset_quiet_R1: assert (!vecDone && !vecAuto && vecNum == '0);
    end
  end

  // R8: strobe lasts exactly one clock
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |=> !vecDone);

  // R2: autovector lies in the generated range
  assert_auto_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (vecDone && vecAuto) |-> (int'(vecNum) >= AUTO_BASE && int'(vecNum) <= AUTO_TOP));

  // R6: a done strobe only follows an acknowledge cycle
  assert_ignore_other_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> ($past(cycleKind) == INTACK_CODE));

  // R7: no autovector while an external master owns the bus
  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecDone && $past(extMasterOwns)) |-> !vecAuto);

  // R4: external vector comes from the device byte on an acknowledge
  assert_ext_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vecDone && !vecAuto) |-> ($past(dataAck) && vecNum == $past(extVector)));

  // R5: an effective autovector request wins over the acknowledge
  assert_auto_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vecDone && $past((extAutoVec || csAutoVec) && !extMasterOwns)) |-> vecAuto);

  // R8: results hold between strobes
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!vecDone && $past(rstN)) |-> ($stable(vecNum) && $stable(vecAuto)));

endmodule

bind ivecResolve ivecResolve_chk #(
  .KIND_W      (KIND_W),
  .LEVEL_W     (LEVEL_W),
  .VEC_W       (VEC_W),
  .AUTO_BASE   (AUTO_BASE),
  .INTACK_CODE (INTACK_CODE)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .cycleKind     (cycleKind),
  .extAutoVec    (extAutoVec),
  .csAutoVec     (csAutoVec),
  .extMasterOwns (extMasterOwns),
  .dataAck       (dataAck),
  .extVector     (extVector),
  .vecNum        (vecNum),
  .vecDone       (vecDone),
  .vecAuto       (vecAuto)
);

// File: tb/sim_ivecResolve.sv
`timescale 1ns/1ps
module sim_ivecResolve;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cycleKind = 2'b00;
  logic [2:0] irqLevel = '0;
  logic       extAutoVec = 1'b0;
  logic       csAutoVec = 1'b0;
  logic       extMasterOwns = 1'b0;
  logic       dataAck = 1'b0;
  logic [7:0] extVector = '0;
  logic [7:0] vecNum;
  logic       vecDone;
  logic       vecAuto;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ivecResolve u0 (
    .clk(clk), .rstN(rstN), .cycleKind(cycleKind), .irqLevel(irqLevel),
    .extAutoVec(extAutoVec), .csAutoVec(csAutoVec), .extMasterOwns(extMasterOwns),
    .dataAck(dataAck), .extVector(extVector),
    .vecNum(vecNum), .vecDone(vecDone), .vecAuto(vecAuto)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit expAuto(bit ea, bit cs, bit master);
    return (ea | cs) & ~master;
  endfunction

  function automatic int expVec(bit isAuto, int lvl, int vb);
    return isAuto ? 24 + lvl : vb;
  endfunction

  task automatic clearInputs();
    cycleKind = 2'b00; extAutoVec = 0; csAutoVec = 0;
    dataAck = 0; extMasterOwns = 0;
  endtask

  // one acknowledge cycle: start, wait edge, resolve edge, hold edge, idle
  task automatic ackCycle(string tag, int lvl, bit ea, bit cs, bit master,
                          bit ack, int vb, bit changeLvl, bit keepReq);
    int prevNum;
    int prevAuto;
    bit a;
    bit d;
    @(negedge clk);
    cycleKind = 2'b11; irqLevel = 3'(lvl); extAutoVec = ea; csAutoVec = cs;
    extMasterOwns = master; dataAck = ack; extVector = 8'(vb);
    prevNum = vecNum; prevAuto = vecAuto;
    @(negedge clk);
    check({tag, " start edge no done"}, vecDone, 0);
    if (changeLvl) irqLevel = ~3'(lvl);
    @(negedge clk);
    a = expAuto(ea, cs, master);
    d = a | ack;
    check({tag, " done"}, vecDone, d);
    if (d) begin
      check({tag, " vecNum"}, vecNum, expVec(a, lvl, vb));
      check({tag, " vecAuto"}, vecAuto, a);
    end else begin
      check({tag, " hold vecNum R8"}, vecNum, prevNum);
      check({tag, " hold vecAuto R8"}, vecAuto, prevAuto);
    end
    @(negedge clk);
    check({tag, " single strobe R8"}, vecDone, 0);
    cycleKind = 2'b00;
    if (!keepReq) clearInputs();
    @(negedge clk);
    check({tag, " no late done R10"}, vecDone, 0);
  endtask

  initial begin
    void'($urandom(32'd20931));
    repeat (3) @(negedge clk);
    check("R1 vecDone after reset", vecDone, 0);
    check("R1 vecAuto after reset", vecAuto, 0);
    check("R1 vecNum after reset", vecNum, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: pin autovector, levels 1 and 7
    ackCycle("R2 pin lvl1", 1, 1, 0, 0, 0, 8'h40, 0, 0);
    ackCycle("R2 pin lvl7", 7, 1, 0, 0, 0, 8'h41, 0, 0);
    // R3: chip-select autovector
    ackCycle("R3 cs lvl4", 4, 0, 1, 0, 0, 8'h42, 0, 0);
    // R4: device vector
    ackCycle("R4 ext vector", 5, 0, 0, 0, 1, 8'hA7, 0, 0);
    // R5: autovector wins over acknowledge
    ackCycle("R5 auto beats ack", 3, 0, 1, 0, 1, 8'h99, 0, 0);
    // R7: external master disables both sources
    ackCycle("R7 master ack", 6, 1, 1, 1, 1, 8'h5C, 0, 0);
    ackCycle("R7 master no ack", 2, 1, 1, 1, 0, 8'h11, 0, 0);
    // R11: level changed in mid-cycle
    ackCycle("R11 level frozen", 2, 1, 0, 0, 0, 8'h00, 1, 0);

    // R6: requests outside acknowledge cycles are ignored
    for (int k = 0; k < 3; k++) begin
      int held;
      @(negedge clk);
      held = vecNum;
      cycleKind = 2'(k); extAutoVec = 1; csAutoVec = 1; dataAck = 1;
      extVector = 8'h77; irqLevel = 3'd5;
      @(negedge clk);
      check("R6 no done outside ack", vecDone, 0);
      @(negedge clk);
      check("R6 no done outside ack 2", vecDone, 0);
      check("R6 vecNum held", vecNum, held);
      clearInputs();
    end

    // R9: request held high across back-to-back cycles
    extAutoVec = 1;
    for (int l = 1; l < 8; l++) ackCycle("R9 continuous", l, 1, 0, 0, 0, 8'h33, 0, 1);
    clearInputs();

    // R10: abort before termination
    @(negedge clk);
    cycleKind = 2'b11; irqLevel = 3'd3;
    @(negedge clk);
    cycleKind = 2'b01; extAutoVec = 1; dataAck = 1;
    @(negedge clk);
    check("R10 abort no done", vecDone, 0);
    clearInputs();
    @(negedge clk);
    check("R10 abort no done later", vecDone, 0);

    // random cycles covering R2 R3 R4 R5 R7
    for (int i = 0; i < 400; i++) begin
      int lvl;
      bit ea;
      bit cs;
      bit ms;
      bit ak;
      int vb;
      lvl = int'($urandom_range(0, 7));
      ea = 1'($urandom); cs = 1'($urandom); ms = 1'($urandom);
      ak = 1'($urandom); vb = int'($urandom_range(0, 255));
      ackCycle("R2 R3 R4 R5 R7 random", lvl, ea, cs, ms, ak, vb,
               1'($urandom_range(0, 3) == 0), 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule